// File: doc/BRIEF.md
# Register Access Serial Slave

This block is the serial front end of a register file. An external controller drives four wires: an active-low chip select, a serial clock that idles low, a serial data input carrying writes, and a serial data output carrying reads. The block oversamples these pins with its own system clock. It decodes a 16-clock command word and then moves any number of data bytes. On the other side it presents a plain register port with an address, a write strobe with write data, a read strobe, and read data coming back.

Every command word names a 15-bit start address and a direction. After each data byte the address steps down by one, and it wraps from the bottom of the space to the top. A single long frame can therefore write, or read back, a descending block of registers. The read strobe marks each byte that has been shifted out completely. Logic behind the port can use it to see which addresses the controller has actually consumed.

The block makes three assumptions. The register file returns `reg_rd_data` combinationally for the current `reg_addr`. The serial clock idles low. Each serial clock half-period lasts at least four system clocks.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset, `spi_sdo_oe`, `spi_sdo`, `reg_wr_en` and `reg_rd_en` are 0 and `reg_addr` is 0.
- R2: The first 16 rising serial clock edges of a frame sample SDI MSB first into a command word. Bit 15 of that word selects the direction (1 = read, 0 = write) and bits 14:0 are the start address, which then appears on `reg_addr`.
- R3: In a write frame, each further group of 8 rising edges forms a byte, MSB first. The block then raises `reg_wr_en` for one cycle, with that byte on `reg_wr_data` and the byte's address on `reg_addr`.
- R4: In a read frame, SDO changes only after falling serial clock edges. At the first falling edge of each byte the block takes `reg_rd_data` for the current `reg_addr` and drives it out MSB first. After the byte's 8th rising edge it raises `reg_rd_en` for one cycle, with that byte's address.
- R5: After every completed data byte, `reg_addr` drops by one in the cycle after the strobe. The next byte then transfers without a new command word.
- R6: Stepping down from address 0x0000 gives address 0x7FFF.
- R7: A read frame of 48 clocks starting at 0x0203 returns the data of 0x0203, 0x0202, 0x0201 and 0x0200 in that order, with exactly four read strobes.
- R8: Chip select going high ends the frame at any point. A partial command word or partial write byte is discarded, with no strobe and no change to `reg_addr`, and the next frame starts with a fresh command word.
- R9: `spi_sdo_oe` is high only while the synchronised chip select is low. SDO stays 0 during the command phase and throughout write frames.
- R10: The write and read strobes each last one cycle, are never high together, and occur only while a frame is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_csb | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, idles low |
| spi_sdi | input | 1 | Serial data into the block |
| spi_sdo | output | 1 | Serial read data out |
| spi_sdo_oe | output | 1 | Output enable for the SDO pad driver |
| reg_addr | output | ADDR_W (15) | Current register address |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_data | output | DATA_W (8) | Write data byte |
| reg_rd_en | output | 1 | One-cycle strobe for a completed read byte |
| reg_rd_data | input | DATA_W (8) | Read data for `reg_addr` |

## Verification
On every cycle, the assertions check the following: the strobes are single-cycle and mutually exclusive, and occur only inside a frame; the address steps down by exactly one after each strobe, including the wrap at zero; SDO holds its value between falling clock edges; and SDO stays quiet outside read data phases. The bench scenarios cover what needs a whole frame to show. These are the correct command decode, the byte values and their MSB-first order on both data lines, the address sequence across a long descending frame, and the rule that an aborted command or byte leaves no trace.

// File: rtl/spi_reg_pkg.sv
// Shared types for the register access serial slave.
package spi_reg_pkg;

    // Frame phase: command/address word, then data bytes.
    typedef enum logic {
        PH_CMD  = 1'b0,
        PH_DATA = 1'b1
    } spi_phase_e;

endpackage

// File: rtl/spi_pin_sync.sv
// Brings chip select, serial clock and serial data into the system clock
// domain through a synchroniser chain, then derives single-cycle rising and
// falling edge pulses of the serial clock.
// Assumes each serial clock level lasts longer than the chain depth.
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic csb_raw,
    input  logic sclk_raw,
    input  logic sdi_raw,
    output logic csb_s,
    output logic sdi_s,
    output logic sclk_rise,
    output logic sclk_fall
);
    // Bit order in each stage: {csb, sclk, sdi}; csb resets to idle high.
    localparam logic [2:0] IDLE = 3'b100;

    logic [2:0] stage_q [STAGES];
    logic       sclk_prev_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            // Move the pin levels one step down the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= IDLE;
                else if (g == 0) stage_q[g] <= {csb_raw, sclk_raw, sdi_raw};
                else stage_q[g] <= stage_q[(g > 0) ? g - 1 : 0];
            end
        end
    endgenerate

    // Remember the previous synchronised serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev_q <= 1'b0;
        else        sclk_prev_q <= stage_q[STAGES-1][1];
    end

    assign csb_s     = stage_q[STAGES-1][2];
    assign sdi_s     = stage_q[STAGES-1][0];
    assign sclk_rise =  stage_q[STAGES-1][1] & ~sclk_prev_q;
    assign sclk_fall = ~stage_q[STAGES-1][1] &  sclk_prev_q;

endmodule

// File: rtl/spi_frame_ctrl.sv
// Frame control: counts serial clock rising edges, assembles the command word
// and the data bytes, holds the register address and issues the one-cycle
// write and read strobes. The address steps down in the cycle after each
// strobe and wraps at zero through plain modular arithmetic.
// Assumes the synchronised inputs come from spi_pin_sync.
module spi_frame_ctrl
    import spi_reg_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csb_s,
    input  logic              sdi_s,
    input  logic              sclk_rise,
    output logic [ADDR_W-1:0] addr,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_en,
    output logic              rd_active,
    output logic              byte_start
);
    localparam int CMD_W = ADDR_W + 1;
    localparam int CNT_W = $clog2(CMD_W);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    spi_phase_e        phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CMD_W-2:0]  shreg_q;
    logic              rnw_q;

    // Shift, count, decode the command and raise strobes at byte boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_CMD;
            cnt_q   <= '0;
            shreg_q <= '0;
            rnw_q   <= 1'b0;
            addr    <= '0;
            wr_en   <= 1'b0;
            rd_en   <= 1'b0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            rd_en <= 1'b0;
            if (wr_en || rd_en) addr <= addr - 1'b1;
            if (csb_s) begin
                phase_q <= PH_CMD;
                cnt_q   <= '0;
            end else if (sclk_rise) begin
                shreg_q <= {shreg_q[CMD_W-3:0], sdi_s};
                if (phase_q == PH_CMD) begin
                    if (cnt_q == CMD_LAST) begin
                        rnw_q   <= shreg_q[CMD_W-2];
                        addr    <= {shreg_q[ADDR_W-2:0], sdi_s};
                        phase_q <= PH_DATA;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end else if (cnt_q == DATA_LAST) begin
                    cnt_q <= '0;
                    if (rnw_q) begin
                        rd_en <= 1'b1;
                    end else begin
                        wr_en   <= 1'b1;
                        wr_data <= {shreg_q[DATA_W-2:0], sdi_s};
                    end
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign rd_active  = (phase_q == PH_DATA) && rnw_q;
    assign byte_start = (cnt_q == '0);

endmodule

// File: rtl/spi_sdo_launch.sv
// Read data launch: at the first falling serial clock edge of each read byte
// it loads the register data, then puts one bit per falling edge on SDO,
// MSB first. SDO is forced low whenever chip select is high.
// Assumes read data is valid for the current address by that falling edge.
module spi_sdo_launch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csb_s,
    input  logic              sclk_fall,
    input  logic              rd_active,
    input  logic              byte_start,
    input  logic [DATA_W-1:0] rd_data,
    output logic              sdo
);
    logic [DATA_W-2:0] sr_q;

    // Load or shift the outgoing byte on falling edges of a read data phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdo  <= 1'b0;
            sr_q <= '0;
        end else if (csb_s) begin
            sdo <= 1'b0;
        end else if (sclk_fall && rd_active) begin
            if (byte_start) begin
                sdo  <= rd_data[DATA_W-1];
                sr_q <= rd_data[DATA_W-2:0];
            end else begin
                sdo  <= sr_q[DATA_W-2];
                sr_q <= {sr_q[DATA_W-3:0], 1'b0};
            end
        end
    end

endmodule

// File: rtl/spi_reg_slave.sv
// Top level of the register access serial slave: pin synchroniser, frame
// control and read data launch. Runs entirely on the system clock.
// Assumes serial clock idles low and each half-period spans >= 4 clk cycles.
module spi_reg_slave #(
    parameter int ADDR_W      = 15,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_csb,
    input  logic              spi_sclk,
    input  logic              spi_sdi,
    output logic              spi_sdo,
    output logic              spi_sdo_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr_en,
    output logic [DATA_W-1:0] reg_wr_data,
    output logic              reg_rd_en,
    input  logic [DATA_W-1:0] reg_rd_data
);
    logic csb_s;
    logic sdi_s;
    logic sclk_rise;
    logic sclk_fall;
    logic rd_active;
    logic byte_start;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .csb_raw   (spi_csb),
        .sclk_raw  (spi_sclk),
        .sdi_raw   (spi_sdi),
        .csb_s     (csb_s),
        .sdi_s     (sdi_s),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall)
    );

    spi_frame_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .csb_s      (csb_s),
        .sdi_s      (sdi_s),
        .sclk_rise  (sclk_rise),
        .addr       (reg_addr),
        .wr_en      (reg_wr_en),
        .wr_data    (reg_wr_data),
        .rd_en      (reg_rd_en),
        .rd_active  (rd_active),
        .byte_start (byte_start)
    );

    spi_sdo_launch #(.DATA_W(DATA_W)) launch_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .csb_s      (csb_s),
        .sclk_fall  (sclk_fall),
        .rd_active  (rd_active),
        .byte_start (byte_start),
        .rd_data    (reg_rd_data),
        .sdo        (spi_sdo)
    );

    assign spi_sdo_oe = ~csb_s;

endmodule

// File: rtl/spi_reg_slave_chk.sv
// Checker for spi_reg_slave: strobe shape, address stepping and SDO timing.
module spi_reg_slave_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              csb_s,
    input logic              sclk_fall,
    input logic              rd_active,
    input logic              spi_sdo,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr_en,
    input logic              reg_rd_en
);
    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_wr_en, reg_rd_en}));

    // R10
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en || reg_rd_en) |=> !(reg_wr_en || reg_rd_en));

    // R10
    strobe_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en || reg_rd_en) |-> $past(!csb_s));

    // R5 (covers the R6 wrap through modular width)
    addr_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en || reg_rd_en) |=> (reg_addr == ADDR_W'($past(reg_addr) - 1'b1)));

    // R4
    sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_fall && !csb_s) |=> $stable(spi_sdo));

    // R9
    sdo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_active |-> !spi_sdo);

endmodule

bind spi_reg_slave spi_reg_slave_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .csb_s     (csb_s),
    .sclk_fall (sclk_fall),
    .rd_active (rd_active),
    .spi_sdo   (spi_sdo),
    .reg_addr  (reg_addr),
    .reg_wr_en (reg_wr_en),
    .reg_rd_en (reg_rd_en)
);

// File: tb/spi_reg_slave_tb_top.sv
module spi_reg_slave_tb_top;
    localparam int HP = 8;  // serial clock half-period in system clocks

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_csb = 1'b1;
    logic        spi_sclk = 1'b0;
    logic        spi_sdi = 1'b0;
    logic        spi_sdo;
    logic        spi_sdo_oe;
    logic [14:0] reg_addr;
    logic        reg_wr_en;
    logic [7:0]  reg_wr_data;
    logic        reg_rd_en;
    logic [7:0]  reg_rd_data;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [14:0] wr_addr_log [8];
    logic [7:0]  wr_data_log [8];
    logic [14:0] rd_addr_log [8];
    int wr_cnt = 0;
    int rd_cnt = 0;

    always #5 clk = ~clk;

    function automatic logic [7:0] model(input logic [14:0] a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h3C;
    endfunction

    assign reg_rd_data = model(reg_addr);

    spi_reg_slave dut_i (
        .clk(clk), .rst_n(rst_n), .spi_csb(spi_csb), .spi_sclk(spi_sclk),
        .spi_sdi(spi_sdi), .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe),
        .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_en(reg_rd_en), .reg_rd_data(reg_rd_data)
    );

    // Strobe monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (reg_wr_en) begin
            if (wr_cnt < 8) begin
                wr_addr_log[wr_cnt] = reg_addr;
                wr_data_log[wr_cnt] = reg_wr_data;
            end
            wr_cnt = wr_cnt + 1;
        end
        if (reg_rd_en) begin
            if (rd_cnt < 8) rd_addr_log[rd_cnt] = reg_addr;
            rd_cnt = rd_cnt + 1;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One frame: ncmd command bits, then ndata data bits MSB first from wbits.
    task automatic run_frame(input logic rnw, input logic [14:0] a,
                             input int ncmd, input int ndata,
                             input logic [31:0] wbits,
                             output logic [31:0] rbits, output logic cmd_sdo);
        logic [15:0] cmd;
        cmd = {rnw, a};
        rbits = '0;
        cmd_sdo = 1'b0;
        wr_cnt = 0;
        rd_cnt = 0;
        spi_csb = 1'b0;
        for (int i = 0; i < ncmd; i++) begin
            spi_sdi = cmd[15-i];
            wait_clk(HP);
            if (spi_sdo !== 1'b0) cmd_sdo = 1'b1;
            spi_sclk = 1'b1;
            wait_clk(HP);
            spi_sclk = 1'b0;
        end
        for (int i = 0; i < ndata; i++) begin
            spi_sdi = wbits[ndata-1-i];
            wait_clk(HP);
            rbits = {rbits[30:0], spi_sdo};
            spi_sclk = 1'b1;
            wait_clk(HP);
            spi_sclk = 1'b0;
        end
        wait_clk(HP);
        spi_csb = 1'b1;
        spi_sdi = 1'b0;
        wait_clk(4 * HP);
    endtask

    // Vector: {rnw, start address, byte count, write data}
    localparam int NV = 7;
    localparam logic [50:0] VEC [NV] = '{
        {1'b1, 15'h0203, 3'd4, 32'h0000_0000},  // R7 long read
        {1'b0, 15'h0010, 3'd2, 32'h0000_A5C3},  // R3 write
        {1'b1, 15'h0001, 3'd3, 32'h0000_0000},  // R6 read across wrap
        {1'b0, 15'h0000, 3'd2, 32'h0000_5A81},  // R6 write across wrap
        {1'b1, 15'h7FFF, 3'd1, 32'h0000_0000},  // R4 single byte read
        {1'b0, 15'h1234, 3'd4, 32'h0F1E_2D3C},  // R5 long write
        {1'b1, 15'h4000, 3'd2, 32'h0000_0000}   // R2 high address read
    };

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rb;
        logic        cs;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);

        // R1 reset state
        chk("R1", "sdo_oe", {31'b0, spi_sdo_oe}, 32'h0);
        chk("R1", "sdo", {31'b0, spi_sdo}, 32'h0);
        chk("R1", "wr_en", {31'b0, reg_wr_en}, 32'h0);
        chk("R1", "rd_en", {31'b0, reg_rd_en}, 32'h0);
        chk("R1", "reg_addr", {17'b0, reg_addr}, 32'h0);

        for (int v = 0; v < NV; v++) begin
            logic        rnw;
            logic [14:0] a;
            int          n;
            logic [31:0] wd;
            rnw = VEC[v][50];
            a   = VEC[v][49:35];
            n   = int'(VEC[v][34:32]);
            wd  = VEC[v][31:0];
            run_frame(rnw, a, 16, 8 * n, wd, rb, cs);
            chk("R9", "sdo during command", {31'b0, cs}, 32'h0);
            chk("R9", "sdo_oe after frame", {31'b0, spi_sdo_oe}, 32'h0);
            chk("R5", "address after frame", {17'b0, reg_addr}, {17'b0, 15'(a - 15'(n))});
            if (rnw) begin
                chk("R4", "read strobe count", rd_cnt, n);
                chk("R10", "no write strobe in read", wr_cnt, 0);
                for (int i = 0; i < n; i++) begin
                    chk("R4", "read strobe address", {17'b0, rd_addr_log[i]}, {17'b0, 15'(a - 15'(i))});
                    chk("R4", "read byte", {24'b0, rb[8*(n-1-i) +: 8]}, {24'b0, model(15'(a - 15'(i)))});
                end
            end else begin
                chk("R3", "write strobe count", wr_cnt, n);
                chk("R9", "sdo in write frame", rb, 32'h0);
                for (int i = 0; i < n; i++) begin
                    chk("R3", "write address", {17'b0, wr_addr_log[i]}, {17'b0, 15'(a - 15'(i))});
                    chk("R3", "write data", {24'b0, wr_data_log[i]}, {24'b0, wd[8*(n-1-i) +: 8]});
                end
            end
        end

        // R7 explicit word check of the 48-clock read
        run_frame(1'b1, 15'h0203, 16, 32, 32'h0, rb, cs);
        chk("R7", "four-byte read", rb, {model(15'h0203), model(15'h0202), model(15'h0201), model(15'h0200)});
        chk("R7", "strobe count", rd_cnt, 4);

        // R8 abort inside a write byte
        run_frame(1'b0, 15'h0055, 16, 5, 32'h1F, rb, cs);
        chk("R8", "partial byte no strobe", wr_cnt, 0);
        chk("R8", "address unchanged", {17'b0, reg_addr}, 32'h0055);

        // R8 abort inside the command word, then a fresh write
        run_frame(1'b1, 15'h0300, 10, 0, 32'h0, rb, cs);
        chk("R8", "partial command no strobe", rd_cnt + wr_cnt, 0);
        run_frame(1'b0, 15'h0066, 16, 8, 32'h99, rb, cs);
        chk("R8", "fresh frame strobe count", wr_cnt, 1);
        chk("R8", "fresh frame address", {17'b0, wr_addr_log[0]}, 32'h0066);
        chk("R8", "fresh frame data", {24'b0, wr_data_log[0]}, 32'h99);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule